// File: doc/BRIEF.md
# Floating-Point Load/Store Address Decoder

This block sits in the issue path of a core and turns one 32-bit instruction word into the control for a floating-point memory access. It recognises the eight floating-point loads and stores that carry a 16-bit signed displacement, the eight indexed forms that add two general registers, and the indexed store that writes the low word of a floating-point register as an integer. For each recognised access it computes the effective address from the two general-register values that the caller read for the instruction. It also reports the access width, the floating-point register involved, and whether the base register must be written back with the new address.

Each request is presented for one cycle with `in_valid`. One cycle later the decoded result appears with `out_valid`. Two cases are kept apart at the outputs. A word that is not one of these accesses is flagged as foreign. An update form that names register 0 as its base is flagged as illegal, and neither an access nor a write-back is requested for it. Memory traffic and the conversion between single and double formats are left to the blocks downstream.

Top module: `fpls_decoder`

## Requirements
- R1: Primary opcode (instruction bits 31:26) values 48 through 55 are displacement forms. In these forms opcode bit 2 means store, bit 1 means double width and bit 0 means base update. Values 47 and 56 are not recognised.
- R2: Primary opcode 31 is an indexed form when the extended opcode (instruction bits 10:1) ANDed with 0x31F equals 0x217. In these forms extended-opcode bit 0x80 means store, 0x40 means double width and 0x20 means base update.
- R3: For a displacement form, `eff_addr` equals the sign-extended bits 15:0 plus `ra_val`, modulo 2^32. If the RA index (bits 20:16) is 0, zero is used in place of `ra_val`.
- R4: For an indexed form, `eff_addr` equals `rb_val` plus `ra_val`, modulo 2^32. If the RA index is 0, zero is used in place of `ra_val`.
- R5: An update form whose RA index is 0 sets `illegal` and clears `acc_en`, `upd_en` and `acc_bytes`.
- R6: Opcode 31 with extended opcode 983 is an integer-word store. It sets `is_intword`, `is_store` and `acc_en`, with `acc_bytes` of 4, `upd_en` low, and the address as in R4.
- R7: A legal update form sets `upd_en`, and `upd_reg` carries the RA index. Whenever `upd_en` is low, `upd_reg` is 0.
- R8: `acc_bytes` is 4 for single-width and integer-word accesses, 8 for double-width accesses, and 0 whenever `acc_en` is low.
- R9: Any other word sets `not_fp` and clears `acc_en`, `upd_en`, `illegal`, `eff_addr` and `fpr_idx`.
- R10: `out_valid` follows `in_valid` one cycle later. While `in_valid` is low, every decoded output holds its value.
- R11: After reset, every output is 0.
- R12: `fpr_idx` carries instruction bits 25:21 for every recognised access, including illegal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word and register values are valid this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | 32 | Value of the general register named by bits 20:16 |
| rb_val | input | 32 | Value of the general register named by bits 15:11 |
| out_valid | output | 1 | Decoded result valid |
| acc_en | output | 1 | A memory access is to be performed |
| eff_addr | output | 32 | Effective address |
| acc_bytes | output | 4 | Access size in bytes (0, 4 or 8) |
| is_store | output | 1 | Access is a store |
| is_double | output | 1 | Access is double width |
| is_intword | output | 1 | Access is the integer-word store |
| fpr_idx | output | 5 | Floating-point register loaded or stored |
| upd_en | output | 1 | Write `eff_addr` back to a general register |
| upd_reg | output | 5 | General register to write back |
| illegal | output | 1 | Update form with base register 0 |
| not_fp | output | 1 | Word is not a floating-point load or store |

## Verification
A wrong classification in the combinational decode appears on the very next `out_valid` cycle as a mismatch among `acc_en`, `not_fp` and `illegal`. The checker rejects any state where more than one of those three is set. A wrong operand choice in the adder, such as using `ra_val` when the index is 0 or skipping the sign extension, appears only in `eff_addr`. The bench exposes it by putting a non-zero value on the unused register input and by choosing negative displacements that wrap. A capture register that loads while `in_valid` is low is caught one cycle later by the hold checks.

// File: rtl/fpls_pkg.sv
// Package: shared constants and types for the FP load/store address decoder.
// Assumes the usual 32-bit instruction layout: primary opcode in bits 31:26,
// extended opcode in bits 10:1 for register-indexed forms.
package fpls_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int XO_W    = 10;
    localparam int REG_W   = 5;
    localparam int DISP_W  = 16;
    localparam int SIZE_W  = 4;

    // Displacement-form primary opcode window; low three bits encode the access.
    localparam logic [OPC_W-1:0] OPC_DISP_LO = 6'd48;
    localparam logic [OPC_W-1:0] OPC_DISP_HI = 6'd55;
    localparam logic [OPC_W-1:0] OPC_EXT     = 6'd31;

    // Indexed-form group: bits 0xE0 of the extended opcode vary, the rest match.
    localparam logic [XO_W-1:0] XO_GRP_MASK = 10'h31F;
    localparam logic [XO_W-1:0] XO_GRP_VAL  = 10'h217;
    localparam logic [XO_W-1:0] XO_INTWORD  = 10'd983;

    // Bit positions of the access attributes inside opcode / extended opcode.
    localparam int DISP_STORE_BIT = 2;
    localparam int DISP_DBL_BIT   = 1;
    localparam int DISP_UPD_BIT   = 0;
    localparam int XO_STORE_BIT   = 7;
    localparam int XO_DBL_BIT     = 6;
    localparam int XO_UPD_BIT     = 5;

    localparam logic [SIZE_W-1:0] BYTES_SINGLE = 4'd4;
    localparam logic [SIZE_W-1:0] BYTES_DOUBLE = 4'd8;

    typedef enum logic [1:0] {
        FORM_NONE    = 2'd0,
        FORM_DISP    = 2'd1,
        FORM_INDEX   = 2'd2,
        FORM_INTWORD = 2'd3
    } form_e;

    typedef struct packed {
        form_e             form;
        logic              store;
        logic              dbl;
        logic              upd_req;
        logic              illegal;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  ra;
    } dec_t;

endpackage

// File: rtl/fpls_classify.sv
// Module: fpls_classify
// Purely combinational instruction classifier. Decides which form (if any)
// the word belongs to, extracts store/double/update from the opcode bits and
// flags update forms that name base register 0. Assumes nothing about
// validity; the caller qualifies the result.
module fpls_classify
    import fpls_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec,
    output logic [DISP_W-1:0] disp
);

    logic [OPC_W-1:0] opcd;
    logic [XO_W-1:0]  xo;
    logic             hit_disp;
    logic             hit_index;
    logic             hit_intword;
    logic             unused_rc_bit;

    assign opcd          = insn[31:26];
    assign xo            = insn[10:1];
    assign disp          = insn[DISP_W-1:0];
    assign unused_rc_bit = insn[0];

    // Form detection: opcode window, indexed group match, integer-word store.
    always_comb begin
        hit_disp    = (opcd >= OPC_DISP_LO) && (opcd <= OPC_DISP_HI);
        hit_index   = (opcd == OPC_EXT) && ((xo & XO_GRP_MASK) == XO_GRP_VAL);
        hit_intword = (opcd == OPC_EXT) && (xo == XO_INTWORD);
    end

    // Attribute extraction per form and illegal-update detection.
    always_comb begin
        dec         = '0;
        dec.rt      = insn[25:21];
        dec.ra      = insn[20:16];
        if (hit_disp) begin
            dec.form    = FORM_DISP;
            dec.store   = opcd[DISP_STORE_BIT];
            dec.dbl     = opcd[DISP_DBL_BIT];
            dec.upd_req = opcd[DISP_UPD_BIT];
        end else if (hit_index) begin
            dec.form    = FORM_INDEX;
            dec.store   = xo[XO_STORE_BIT];
            dec.dbl     = xo[XO_DBL_BIT];
            dec.upd_req = xo[XO_UPD_BIT];
        end else if (hit_intword) begin
            dec.form    = FORM_INTWORD;
            dec.store   = 1'b1;
        end else begin
            dec.form    = FORM_NONE;
            dec.rt      = '0;
            dec.ra      = '0;
        end
        dec.illegal = dec.upd_req && (dec.ra == '0);
    end

endmodule

// File: rtl/fpls_agen.sv
// Module: fpls_agen
// Combinational effective-address adder. Base is the RA value, or zero when
// the RA index is 0; offset is the sign-extended displacement for displacement
// forms and the RB value otherwise. Assumes XLEN >= DISP_W.
module fpls_agen
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  form_e             form,
    input  logic [REG_W-1:0]  ra_idx,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    output logic [XLEN-1:0]   ea
);

    localparam int EXT_W = XLEN - DISP_W;

    logic [XLEN-1:0] disp_ext;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Sign extension of the displacement, sized by parameter.
    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        end else begin : g_noext
            assign disp_ext = disp[XLEN-1:0];
        end
    endgenerate

    // Operand selection: register 0 as base reads as literal zero.
    always_comb begin
        base   = (ra_idx == '0) ? '0 : ra_val;
        offset = (form == FORM_DISP) ? disp_ext : rb_val;
    end

    // Sum; unrecognised words produce a zero address.
    always_comb begin
        if (form == FORM_NONE) ea = '0;
        else                   ea = base + offset;
    end

endmodule

// File: rtl/fpls_outreg.sv
// Module: fpls_outreg
// Output stage: derives the access enables and size from the decode and
// captures everything on a valid request. Outputs hold while no request is
// presented. Synchronous active-low reset clears all state.
module fpls_outreg
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  dec_t              dec,
    input  logic [XLEN-1:0]   ea,
    output logic              out_valid,
    output logic              acc_en,
    output logic [XLEN-1:0]   eff_addr,
    output logic [SIZE_W-1:0] acc_bytes,
    output logic              is_store,
    output logic              is_double,
    output logic              is_intword,
    output logic [REG_W-1:0]  fpr_idx,
    output logic              upd_en,
    output logic [REG_W-1:0]  upd_reg,
    output logic              illegal,
    output logic              not_fp
);

    logic              nx_acc;
    logic              nx_upd;
    logic              nx_nfp;
    logic [SIZE_W-1:0] nx_bytes;

    // Next-state derivation of enables and access size.
    always_comb begin
        nx_nfp   = (dec.form == FORM_NONE);
        nx_acc   = !nx_nfp && !dec.illegal;
        nx_upd   = nx_acc && dec.upd_req;
        if (!nx_acc)      nx_bytes = '0;
        else if (dec.dbl) nx_bytes = BYTES_DOUBLE;
        else              nx_bytes = BYTES_SINGLE;
    end

    // Valid flag tracks the request with one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result capture on valid requests only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_en     <= 1'b0;
            eff_addr   <= '0;
            acc_bytes  <= '0;
            is_store   <= 1'b0;
            is_double  <= 1'b0;
            is_intword <= 1'b0;
            fpr_idx    <= '0;
            upd_en     <= 1'b0;
            upd_reg    <= '0;
            illegal    <= 1'b0;
            not_fp     <= 1'b0;
        end else if (in_valid) begin
            acc_en     <= nx_acc;
            eff_addr   <= ea;
            acc_bytes  <= nx_bytes;
            is_store   <= dec.store;
            is_double  <= dec.dbl;
            is_intword <= (dec.form == FORM_INTWORD);
            fpr_idx    <= dec.rt;
            upd_en     <= nx_upd;
            upd_reg    <= nx_upd ? dec.ra : '0;
            illegal    <= dec.illegal;
            not_fp     <= nx_nfp;
        end
    end

endmodule

// File: rtl/fpls_decoder.sv
// Module: fpls_decoder (top)
// Decodes floating-point load/store instructions into an effective address
// and access controls, registered with one cycle of latency. Assumes the
// caller has already read the two general registers named by the word.
module fpls_decoder
    import fpls_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    output logic              out_valid,
    output logic              acc_en,
    output logic [XLEN-1:0]   eff_addr,
    output logic [3:0]        acc_bytes,
    output logic              is_store,
    output logic              is_double,
    output logic              is_intword,
    output logic [4:0]        fpr_idx,
    output logic              upd_en,
    output logic [4:0]        upd_reg,
    output logic              illegal,
    output logic              not_fp
);

    dec_t              dec;
    logic [DISP_W-1:0] disp;
    logic [XLEN-1:0]   ea;

    fpls_classify u_classify (
        .insn (insn),
        .dec  (dec),
        .disp (disp)
    );

    fpls_agen #(.XLEN(XLEN)) u_agen (
        .form   (dec.form),
        .ra_idx (dec.ra),
        .disp   (disp),
        .ra_val (ra_val),
        .rb_val (rb_val),
        .ea     (ea)
    );

    fpls_outreg #(.XLEN(XLEN)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .dec        (dec),
        .ea         (ea),
        .out_valid  (out_valid),
        .acc_en     (acc_en),
        .eff_addr   (eff_addr),
        .acc_bytes  (acc_bytes),
        .is_store   (is_store),
        .is_double  (is_double),
        .is_intword (is_intword),
        .fpr_idx    (fpr_idx),
        .upd_en     (upd_en),
        .upd_reg    (upd_reg),
        .illegal    (illegal),
        .not_fp     (not_fp)
    );

endmodule

// File: rtl/fpls_decoder_sva.sv
// Module: fpls_decoder_sva
// Property checker for fpls_decoder, bound to every instance. Observes the
// top-level ports only.
module fpls_decoder_sva #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic            acc_en,
    input logic [XLEN-1:0] eff_addr,
    input logic [3:0]      acc_bytes,
    input logic            is_store,
    input logic            is_intword,
    input logic [4:0]      fpr_idx,
    input logic            upd_en,
    input logic [4:0]      upd_reg,
    input logic            illegal,
    input logic            not_fp
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(eff_addr) && $stable(fpr_idx) && $stable(acc_en))); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $onehot0({not_fp, illegal, acc_en})); // R9
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && illegal) |-> (!acc_en && !upd_en && acc_bytes == 4'd0)); // R5
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && acc_en) |-> (acc_bytes == 4'd4 || acc_bytes == 4'd8)); // R8
    AST_INTWORD_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && is_intword) |-> (is_store && acc_bytes == 4'd4 && !upd_en)); // R6
    AST_UPDATE_BASE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && upd_en) |-> (acc_en && upd_reg != 5'd0)); // R7
    AST_NOUPD_REG: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !upd_en) |-> (upd_reg == 5'd0)); // R7
    AST_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && not_fp) |-> (eff_addr == '0 && fpr_idx == 5'd0 && !upd_en)); // R9

endmodule

bind fpls_decoder fpls_decoder_sva #(.XLEN(XLEN)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .acc_en     (acc_en),
    .eff_addr   (eff_addr),
    .acc_bytes  (acc_bytes),
    .is_store   (is_store),
    .is_intword (is_intword),
    .fpr_idx    (fpr_idx),
    .upd_en     (upd_en),
    .upd_reg    (upd_reg),
    .illegal    (illegal),
    .not_fp     (not_fp)
);

// File: tb/fpls_decoder_test.sv
// Directed bench for fpls_decoder: one task per scenario, each self-checking.
module fpls_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] ra_val = '0;
    logic [31:0] rb_val = '0;
    logic        out_valid, acc_en, is_store, is_double, is_intword;
    logic        upd_en, illegal, not_fp;
    logic [31:0] eff_addr;
    logic [3:0]  acc_bytes;
    logic [4:0]  fpr_idx, upd_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fpls_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .ra_val(ra_val), .rb_val(rb_val), .out_valid(out_valid),
        .acc_en(acc_en), .eff_addr(eff_addr), .acc_bytes(acc_bytes),
        .is_store(is_store), .is_double(is_double), .is_intword(is_intword),
        .fpr_idx(fpr_idx), .upd_en(upd_en), .upd_reg(upd_reg),
        .illegal(illegal), .not_fp(not_fp)
    );

    function automatic logic [31:0] dform(input int op, input int rt, input int ra, input logic [15:0] d);
        return {op[5:0], rt[4:0], ra[4:0], d};
    endfunction

    function automatic logic [31:0] xform(input int xo, input int rt, input int ra, input int rb);
        return {6'd31, rt[4:0], ra[4:0], rb[4:0], xo[9:0], 1'b0};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Present one request; return at the negedge where its result is visible.
    task automatic send(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        insn = w; ra_val = a; rb_val = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_access(input string req, input logic [31:0] ea, input int bytes,
                                 input bit st, input bit dbl, input int rt, input bit upd, input int ureg);
        chk(req, "out_valid", out_valid, 1);
        chk(req, "acc_en", acc_en, 1);
        chk(req, "eff_addr", eff_addr, ea);
        chk(req, "acc_bytes", acc_bytes, bytes);
        chk(req, "is_store", is_store, st);
        chk(req, "is_double", is_double, dbl);
        chk(req, "fpr_idx", fpr_idx, rt);
        chk(req, "upd_en", upd_en, upd);
        chk(req, "upd_reg", upd_reg, ureg);
        chk(req, "illegal", illegal, 0);
        chk(req, "not_fp", not_fp, 0);
    endtask

    task automatic t_reset;
        chk("R11", "out_valid", out_valid, 0);
        chk("R11", "acc_en", acc_en, 0);
        chk("R11", "eff_addr", eff_addr, 0);
        chk("R11", "acc_bytes", acc_bytes, 0);
        chk("R11", "fpr_idx", fpr_idx, 0);
        chk("R11", "flags", {is_store, is_double, is_intword, upd_en, illegal, not_fp}, 0);
        chk("R11", "upd_reg", upd_reg, 0);
    endtask

    task automatic t_disp_load_single; // R1 R3 R8 R12
        send(dform(48, 3, 5, 16'hFFF8), 32'h0000_1000, 32'hAAAA_AAAA);
        expect_access("R3", 32'h0000_0FF8, 4, 0, 0, 3, 0, 0);
    endtask

    task automatic t_disp_store_double_update; // R1 R7
        send(dform(55, 7, 9, 16'h0010), 32'h0000_2000, 32'h0);
        expect_access("R7", 32'h0000_2010, 8, 1, 1, 7, 1, 9);
    endtask

    task automatic t_disp_all_opcodes; // R1 R8
        for (int op = 48; op <= 55; op++) begin
            send(dform(op, 2, 4, 16'h0004), 32'h0000_0100, 32'h0);
            expect_access("R1", 32'h0000_0104, ((op >> 1) & 1) ? 8 : 4,
                          (op >> 2) & 1, (op >> 1) & 1, 2, op & 1, (op & 1) ? 4 : 0);
        end
    endtask

    task automatic t_disp_ra_zero_and_wrap; // R3
        send(dform(50, 1, 0, 16'h7FFC), 32'hDEAD_0000, 32'h0);
        expect_access("R3", 32'h0000_7FFC, 8, 0, 1, 1, 0, 0);
        send(dform(48, 1, 1, 16'hFFF8), 32'h0000_0004, 32'h0);
        expect_access("R3", 32'hFFFF_FFFC, 4, 0, 0, 1, 0, 0);
    endtask

    task automatic t_indexed_forms; // R2 R4 R7 R8
        for (int k = 0; k < 8; k++) begin
            int xo;
            xo = 'h217 | (((k >> 2) & 1) << 7) | (((k >> 1) & 1) << 6) | ((k & 1) << 5);
            send(xform(xo, 11, 4, 6), 32'h0000_0100, 32'h0000_0020);
            expect_access("R2", 32'h0000_0120, ((k >> 1) & 1) ? 8 : 4,
                          (k >> 2) & 1, (k >> 1) & 1, 11, k & 1, (k & 1) ? 4 : 0);
        end
    endtask

    task automatic t_indexed_ra_zero; // R4
        send(xform('h257, 30, 0, 6), 32'h0000_0005, 32'h0000_3000);
        expect_access("R4", 32'h0000_3000, 8, 0, 1, 30, 0, 0);
        send(xform('h297, 30, 2, 6), 32'hFFFF_FFF0, 32'h0000_0020);
        expect_access("R4", 32'h0000_0010, 4, 1, 0, 30, 0, 0);
    endtask

    task automatic t_update_ra_zero; // R5 R12
        send(dform(49, 6, 0, 16'h0040), 32'h0000_1000, 32'h0);
        chk("R5", "illegal", illegal, 1);
        chk("R5", "acc_en", acc_en, 0);
        chk("R5", "upd_en", upd_en, 0);
        chk("R5", "acc_bytes", acc_bytes, 0);
        chk("R12", "fpr_idx", fpr_idx, 6);
        send(xform('h277, 8, 0, 3), 32'h0, 32'h0000_0800);
        chk("R5", "illegal idx", illegal, 1);
        chk("R5", "acc_en idx", acc_en, 0);
        chk("R5", "upd_reg idx", upd_reg, 0);
        chk("R5", "not_fp idx", not_fp, 0);
    endtask

    task automatic t_intword; // R6
        send(xform(983, 12, 2, 3), 32'h0000_0040, 32'h0000_0004);
        chk("R6", "is_intword", is_intword, 1);
        expect_access("R6", 32'h0000_0044, 4, 1, 0, 12, 0, 0);
        send(xform(983, 12, 0, 3), 32'h0000_0040, 32'h0000_0004);
        chk("R6", "ea ra0", eff_addr, 32'h0000_0004);
        chk("R6", "upd_en ra0", upd_en, 0);
    endtask

    task automatic t_not_fp; // R9 R1
        logic [31:0] words [4];
        words[0] = xform(266, 3, 4, 5);
        words[1] = dform(47, 3, 4, 16'h0010);
        words[2] = dform(56, 3, 4, 16'h0010);
        words[3] = xform('h207, 3, 4, 5);
        for (int i = 0; i < 4; i++) begin
            send(words[i], 32'h1234_5678, 32'h0000_1111);
            chk("R9", "not_fp", not_fp, 1);
            chk("R9", "acc_en", acc_en, 0);
            chk("R9", "upd_en", upd_en, 0);
            chk("R9", "illegal", illegal, 0);
            chk("R9", "eff_addr", eff_addr, 0);
            chk("R9", "fpr_idx", fpr_idx, 0);
        end
    endtask

    task automatic t_hold_and_pipeline; // R10
        send(dform(54, 13, 7, 16'h0008), 32'h0000_0500, 32'h0);
        @(negedge clk);
        insn = dform(48, 1, 1, 16'h0000); ra_val = 32'h9999_0000;
        @(negedge clk);
        chk("R10", "out_valid idle", out_valid, 0);
        chk("R10", "eff_addr held", eff_addr, 32'h0000_0508);
        chk("R10", "fpr_idx held", fpr_idx, 13);
        @(negedge clk);
        insn = dform(50, 3, 2, 16'h0010); ra_val = 32'h100; in_valid = 1'b1;
        @(negedge clk);
        chk("R10", "first ea", eff_addr, 32'h0000_0110);
        chk("R10", "first valid", out_valid, 1);
        insn = xform('h217, 4, 2, 3); ra_val = 32'h200; rb_val = 32'h3;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "second ea", eff_addr, 32'h0000_0203);
        chk("R10", "second fpr", fpr_idx, 4);
        @(negedge clk);
        chk("R10", "valid drops", out_valid, 0);
    endtask

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_disp_load_single();
        t_disp_store_double_update();
        t_disp_all_opcodes();
        t_disp_ra_zero_and_wrap();
        t_indexed_forms();
        t_indexed_ra_zero();
        t_update_ra_zero();
        t_intword();
        t_not_fp();
        t_hold_and_pipeline();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule